// File: doc/BRIEF.md
# Synchronous-Rectified Forward Converter Gate Timing Generator

This block drives the three switches of a single-switch forward converter at a fixed switching frequency: the primary switch, the forward synchronous rectifier and the freewheeling synchronous rectifier. A free-running period counter marks each switching cycle. The primary on-time is ended by a peak-current comparator trip input or by a maximum-duty limit. Programmable lead and dead times place the rectifier edges around the primary pulse. The default period of 571 clocks gives about 350 kHz from a 200 MHz clock.

A mode input chooses how the rectifiers run. In discontinuous-conduction mode the forward rectifier turns on at the start of the period, ahead of the primary switch, so the switch node can discharge before the primary turns on. In that mode the freewheeling rectifier is the complement pulse gated by an auxiliary duty window, which cuts it off when the inductor current reaches zero. In continuous-conduction mode the rectifiers follow the primary pulse and its complement. In the hold-off modes both rectifiers stay off and the primary keeps switching. All settings are double-buffered and take effect at a period boundary.

Top module: `fwd_sr_pwm`

## Requirements
- R1: While `rst_n` is low, and for the first full period after it is released, all three gate outputs are low.
- R2: A period lasts `PERIOD_CYC` clocks. `mode_sel`, `lead_cyc`, `dead_cyc` and `aux_cyc` are captured in the last clock of a period and take effect from the next period. A change in the middle of a period does not alter that period's gates.
- R3: In DCM (`mode_sel` = 2), `fwd_gate` rises at period position 0 and `pri_gate` rises at position `lead_cyc`.
- R4: In every other mode (`mode_sel` = 0, 1, 3), `pri_gate` rises at position 0 and `lead_cyc` is ignored.
- R5: If `cs_trip` is sampled high at a rising edge while the primary is on, `pri_gate` is low from the following edge. A trip sampled while the primary is off (during the lead time) is ignored.
- R6: `pri_gate` is never high at or after position `PERIOD_CYC*MAX_DUTY_PCT/100`. It falls there if no trip has come.
- R7: In DCM, `fwd_gate` falls in the same clock as `pri_gate`.
- R8: The complement pulse rises `dead_cyc` clocks after `pri_gate` falls and lasts until the end of the period. It never overlaps `pri_gate`.
- R9: In DCM, `fw_gate` is the complement pulse ANDed with the auxiliary window, which is high at positions below `aux_cyc`.
- R10: In CCM (`mode_sel` = 1), `fwd_gate` equals `pri_gate` and `fw_gate` equals the complement pulse.
- R11: In the hold-off modes (`mode_sel` = 0 or 3), `fwd_gate` and `fw_gate` stay low while `pri_gate` keeps switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_trip | input | 1 | Peak-current comparator trip, synchronous to `clk` |
| mode_sel | input | 2 | 0/3 rectifiers held off, 1 CCM, 2 DCM |
| lead_cyc | input | W | DCM delay of primary turn-on after period start, in clocks |
| dead_cyc | input | W | Delay from primary turn-off to complement turn-on, in clocks |
| aux_cyc | input | W | Auxiliary (volt-second) window length from period start, in clocks |
| pri_gate | output | 1 | Primary switch gate |
| fwd_gate | output | 1 | Forward synchronous rectifier gate |
| fw_gate | output | 1 | Freewheeling synchronous rectifier gate |

W is `$clog2(PERIOD_CYC+1)`.

## Verification
The assertions assume that `lead_cyc` is below the maximum-duty position, so the primary turns on in every armed period. They also assume that `cs_trip` is already synchronous to `clk`. The bench keeps every lead value under that limit and drives the trip input only at falling edges. It pulses the trip once per measured period, at a position chosen so that some vectors trip during the lead time and are ignored, and others trip during the on-time. Each vector also rewrites all settings in the middle of the measured period, to show that the buffered copies hold.

// File: rtl/fwd_sr_pwm_pkg.sv
// Shared types for the forward-converter gate timing generator.
package fwd_sr_pwm_pkg;

    // Rectifier operating mode; the encoding is the value on mode_sel.
    typedef enum logic [1:0] {
        FSR_HOLD   = 2'd0,
        FSR_CCM    = 2'd1,
        FSR_DCM    = 2'd2,
        FSR_HOLD_B = 2'd3
    } fsr_mode_t;

endpackage

// File: rtl/fwd_sr_pwm_frame.sv
// Period frame: free-running position counter, end-of-period strobe,
// shadow copies of the settings loaded at the period boundary, and an
// "armed" flag that keeps the gates quiet for the first period after reset.
// Assumes the settings are stable during the last clock of a period.
module fwd_sr_pwm_frame
    import fwd_sr_pwm_pkg::*;
#(
    parameter int PERIOD_CYC = 571,
    parameter int W          = $clog2(PERIOD_CYC + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_in,
    input  logic [W-1:0] lead_in,
    input  logic [W-1:0] dead_in,
    input  logic [W-1:0] aux_in,
    output logic [W-1:0] pos_o,
    output logic         wrap_o,
    output fsr_mode_t    mode_o,
    output logic [W-1:0] lead_o,
    output logic [W-1:0] dead_o,
    output logic [W-1:0] aux_o,
    output logic         armed_o
);

    localparam logic [W-1:0] LAST_POS = W'(PERIOD_CYC - 1);

    assign wrap_o = (pos_o == LAST_POS);

    // Position counter: counts 0..PERIOD_CYC-1 and wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)      pos_o <= '0;
        else if (wrap_o) pos_o <= '0;
        else             pos_o <= pos_o + 1'b1;
    end

    // Shadow registers: settings take effect only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= FSR_HOLD;
            lead_o <= '0;
            dead_o <= '0;
            aux_o  <= '0;
        end else if (wrap_o) begin
            mode_o <= fsr_mode_t'(mode_in);
            lead_o <= lead_in;
            dead_o <= dead_in;
            aux_o  <= aux_in;
        end
    end

    // Arm flag: set at the first period boundary after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed_o <= 1'b0;
        else if (wrap_o) armed_o <= 1'b1;
    end

    // R2
    period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (pos_o == '0));

endmodule

// File: rtl/fwd_sr_pwm_primary.sv
// Primary on-time: opens the on-window at the lead position (DCM only),
// latches the current-sense trip, forces off at the maximum-duty position,
// and builds the complement pulse after the dead time.
// Assumes lead < maximum-duty position and cs_trip is synchronous.
module fwd_sr_pwm_primary
    import fwd_sr_pwm_pkg::*;
#(
    parameter int PERIOD_CYC   = 571,
    parameter int MAX_DUTY_PCT = 50,
    parameter int W            = $clog2(PERIOD_CYC + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_trip,
    input  logic [W-1:0] pos_i,
    input  logic         wrap_i,
    input  fsr_mode_t    mode_i,
    input  logic [W-1:0] lead_i,
    input  logic [W-1:0] dead_i,
    output logic         pri_on_o,
    output logic         done_o,
    output logic         comp_o
);

    localparam logic [W-1:0] MAX_ON = W'((PERIOD_CYC * MAX_DUTY_PCT) / 100);

    logic [W-1:0] lead_eff;
    logic         trip_q;
    logic [W-1:0] gap_q;

    // Effective lead: only DCM delays the primary behind the forward rectifier.
    assign lead_eff = (mode_i == FSR_DCM) ? lead_i : '0;
    assign pri_on_o = (pos_i >= lead_eff) && (pos_i < MAX_ON) && !trip_q;
    assign done_o   = trip_q || (pos_i >= MAX_ON);
    assign comp_o   = done_o && (gap_q >= dead_i);

    // Trip latch: armed only while the primary conducts, cleared each period.
    always_ff @(posedge clk) begin
        if (!rst_n || wrap_i)        trip_q <= 1'b0;
        else if (cs_trip && pri_on_o) trip_q <= 1'b1;
    end

    // Dead-time counter: clocks elapsed since the primary went off.
    always_ff @(posedge clk) begin
        if (!rst_n || wrap_i)        gap_q <= '0;
        else if (done_o && gap_q != '1) gap_q <= gap_q + 1'b1;
    end

    // R5
    trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_q && !wrap_i) |=> !pri_on_o);

endmodule

// File: rtl/fwd_sr_pwm_gates.sv
// Gate output stage: maps primary state and auxiliary window onto the three
// gates according to the mode, and registers them so the pins never glitch.
// Assumes all inputs come from registers of the same clock domain.
module fwd_sr_pwm_gates
    import fwd_sr_pwm_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         armed_i,
    input  fsr_mode_t    mode_i,
    input  logic [W-1:0] pos_i,
    input  logic [W-1:0] aux_i,
    input  logic         pri_on_i,
    input  logic         done_i,
    input  logic         comp_i,
    output logic         pri_q,
    output logic         fwd_q,
    output logic         fw_q
);

    logic fwd_n;
    logic fw_n;

    // Rectifier decode per mode.
    always_comb begin
        unique case (mode_i)
            FSR_DCM: begin
                fwd_n = !done_i;
                fw_n  = comp_i && (pos_i < aux_i);
            end
            FSR_CCM: begin
                fwd_n = pri_on_i;
                fw_n  = comp_i;
            end
            default: begin
                fwd_n = 1'b0;
                fw_n  = 1'b0;
            end
        endcase
    end

    // Output registers, quiet until the frame is armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed_i) begin
            pri_q <= 1'b0;
            fwd_q <= 1'b0;
            fw_q  <= 1'b0;
        end else begin
            pri_q <= pri_on_i;
            fwd_q <= fwd_n;
            fw_q  <= fw_n;
        end
    end

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_q && fw_q));

    // R7
    dcm_fwd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode_i) == FSR_DCM) && $fell(pri_q)) |-> $fell(fwd_q));

    // R10
    ccm_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == FSR_CCM) |-> (fwd_q == pri_q));

    // R11
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode_i) == FSR_HOLD) || ($past(mode_i) == FSR_HOLD_B))
            |-> (!fwd_q && !fw_q));

endmodule

// File: rtl/fwd_sr_pwm.sv
// Top: fixed-frequency gate timing for a synchronous-rectified forward
// converter. Assumes cs_trip is synchronised and lead_cyc < max-duty position.
module fwd_sr_pwm
    import fwd_sr_pwm_pkg::*;
#(
    parameter int PERIOD_CYC   = 571,
    parameter int MAX_DUTY_PCT = 50,
    parameter int W            = $clog2(PERIOD_CYC + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_trip,
    input  logic [1:0]   mode_sel,
    input  logic [W-1:0] lead_cyc,
    input  logic [W-1:0] dead_cyc,
    input  logic [W-1:0] aux_cyc,
    output logic         pri_gate,
    output logic         fwd_gate,
    output logic         fw_gate
);

    logic [W-1:0] pos;
    logic         wrap;
    fsr_mode_t    mode_s;
    logic [W-1:0] lead_s;
    logic [W-1:0] dead_s;
    logic [W-1:0] aux_s;
    logic         armed;
    logic         pri_on;
    logic         done;
    logic         comp;

    fwd_sr_pwm_frame #(.PERIOD_CYC(PERIOD_CYC), .W(W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .mode_in(mode_sel), .lead_in(lead_cyc), .dead_in(dead_cyc), .aux_in(aux_cyc),
        .pos_o(pos), .wrap_o(wrap),
        .mode_o(mode_s), .lead_o(lead_s), .dead_o(dead_s), .aux_o(aux_s),
        .armed_o(armed)
    );

    fwd_sr_pwm_primary #(.PERIOD_CYC(PERIOD_CYC), .MAX_DUTY_PCT(MAX_DUTY_PCT), .W(W)) u_primary (
        .clk(clk), .rst_n(rst_n), .cs_trip(cs_trip),
        .pos_i(pos), .wrap_i(wrap), .mode_i(mode_s),
        .lead_i(lead_s), .dead_i(dead_s),
        .pri_on_o(pri_on), .done_o(done), .comp_o(comp)
    );

    fwd_sr_pwm_gates #(.W(W)) u_gates (
        .clk(clk), .rst_n(rst_n), .armed_i(armed), .mode_i(mode_s),
        .pos_i(pos), .aux_i(aux_s),
        .pri_on_i(pri_on), .done_i(done), .comp_i(comp),
        .pri_q(pri_gate), .fwd_q(fwd_gate), .fw_q(fw_gate)
    );

endmodule

// File: tb/test_fwd_sr_pwm.sv
module test_fwd_sr_pwm;

    localparam int P  = 40;
    localparam int W  = $clog2(P + 1);
    localparam int NV = 7;
    localparam int NONE = 99;

    // {mode, lead, dead, aux, trip_pos, pri_rise, pri_fall, fwd_rise, fwd_fall, fw_rise, fw_fall}
    // Max-duty position is 20; 40 means "never" for rise/fall.
    localparam int VEC [NV][11] = '{
        '{2, 4, 2, 30,    9,  4, 11,  0, 11, 13, 30},
        '{2, 6, 3, 16, NONE,  6, 20,  0, 20, 40, 40},
        '{1, 6, 2,  0,    7,  0,  9,  0,  9, 11, 40},
        '{0, 3, 1,  0,   10,  0, 12, 40, 40, 40, 40},
        '{2, 5, 0, 39,    2,  5, 20,  0, 20, 20, 39},
        '{1, 0, 5,  0, NONE,  0, 20,  0, 20, 25, 40},
        '{3, 2, 1,  0,    4,  0,  6, 40, 40, 40, 40}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_trip = 1'b0;
    logic [1:0]   mode_sel = '0;
    logic [W-1:0] lead_cyc = '0;
    logic [W-1:0] dead_cyc = '0;
    logic [W-1:0] aux_cyc = '0;
    logic         pri_gate, fwd_gate, fw_gate;

    int total = 0;
    int bad = 0;
    int pos = 0;
    int rise [3];
    int fall [3];

    always #2.5 clk = ~clk;

    fwd_sr_pwm #(.PERIOD_CYC(P), .MAX_DUTY_PCT(50)) i_fwd_sr_pwm (
        .clk(clk), .rst_n(rst_n), .cs_trip(cs_trip),
        .mode_sel(mode_sel), .lead_cyc(lead_cyc), .dead_cyc(dead_cyc), .aux_cyc(aux_cyc),
        .pri_gate(pri_gate), .fwd_gate(fwd_gate), .fw_gate(fw_gate)
    );

    task automatic chk(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        pos = (pos + 1) % P;
    endtask

    task automatic load(input int v);
        mode_sel = 2'(VEC[v][0]);
        lead_cyc = W'(VEC[v][1]);
        dead_cyc = W'(VEC[v][2]);
        aux_cyc  = W'(VEC[v][3]);
    endtask

    // One period from position 0: record edges, pulse trip, scramble settings mid-period.
    task automatic measure(input int tpos);
        logic s [3];
        for (int k = 0; k < 3; k++) begin
            rise[k] = P;
            fall[k] = P;
        end
        for (int p = 0; p < P; p++) begin
            s[0] = pri_gate; s[1] = fwd_gate; s[2] = fw_gate;
            for (int k = 0; k < 3; k++) begin
                if (s[k] && rise[k] == P) rise[k] = p;
                if (!s[k] && rise[k] != P && fall[k] == P) fall[k] = p;
            end
            cs_trip = (p == tpos);
            if (p == 5) begin // R2: these must not touch the current period
                mode_sel = 2'd0; lead_cyc = W'(1); dead_cyc = W'(7); aux_cyc = '0;
            end
            step();
        end
        cs_trip = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int highs;
        load(0);
        repeat (4) @(negedge clk);
        chk(int'({pri_gate, fwd_gate, fw_gate}), 0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        pos = 0;
        // R1: first period after release stays quiet
        highs = 0;
        for (int p = 0; p < P; p++) begin
            highs += int'(pri_gate) + int'(fwd_gate) + int'(fw_gate);
            step();
        end
        chk(highs, 0, "R1 first period");

        // Vector table: setup period (except the first), then measured period
        for (int v = 0; v < NV; v++) begin
            if (v > 0) begin
                load(v);
                for (int p = 0; p < P; p++) step();
            end
            measure(VEC[v][4]);
            chk(rise[0], VEC[v][5],  $sformatf("R3 R4 R2 pri rise vec%0d", v));
            chk(fall[0], VEC[v][6],  $sformatf("R5 R6 pri fall vec%0d", v));
            chk(rise[1], VEC[v][7],  $sformatf("R3 R10 R11 fwd rise vec%0d", v));
            chk(fall[1], VEC[v][8],  $sformatf("R7 R10 R11 fwd fall vec%0d", v));
            chk(rise[2], VEC[v][9],  $sformatf("R8 R9 R10 R11 fw rise vec%0d", v));
            chk(fall[2], VEC[v][10], $sformatf("R8 R9 fw fall vec%0d", v));
        end

        // Mid-period reset clears the gates at the next edge
        load(0);
        for (int p = 0; p < P; p++) step();
        for (int p = 0; p < 6; p++) step();
        chk(int'(fwd_gate), 1, "R3 fwd high before reset");
        rst_n = 1'b0;
        step();
        chk(int'({pri_gate, fwd_gate, fw_gate}), 0, "R1 mid-period reset");
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule